// File: doc/BRIEF.md
# Frequency-Error Loop Integrator

This block closes a digital frequency-locked loop. Two corrected channel words arrive together with one valid strobe at the loop sample rate, which is a few hundred hertz. The block subtracts the second channel word from the first to get a signed frequency error. It adds that error into a wide accumulator that saturates at its signed limits instead of wrapping.

A programmable arithmetic right shift scales the integrated value and sets the loop gain, and with it the position of the loop's single dominant pole. The most significant bits of the scaled value form an unsigned, offset-binary fine control code for the oscillator. In lock the loop error averages to zero and the code moves back and forth between two neighbouring values.

A preset port loads the accumulator so that the output shows a chosen code at the current shift. The output code and its update strobe are registered. They change on the clock edge that captures a valid error word or a preset load.

Top module: `fll_err_integrator`

## Requirements
- R1: After synchronous reset the accumulator is zero, the control code is mid-scale (4096) and the update strobe is low.
- R2: The frequency error is the first channel word minus the second channel word. Both words are 18-bit two's complement, and the difference is taken at full 19-bit precision.
- R3: The accumulator adds the error once for each cycle in which the valid strobe is high. In any other cycle without a preset load it holds its value.
- R4: The 24-bit accumulator saturates at +8388607 and at -8388608. It never wraps, so with a positive error it never decreases and with a negative error it never increases.
- R5: The control code is the upper 13 bits of the accumulator after an arithmetic right shift by the shift setting (0 to 7), with the top bit inverted. In other words, code = floor(acc / 2^(11+shift)) + 4096.
- R6: The control code and the update strobe are registered. Both change at the clock edge that samples the valid strobe. The strobe is high for exactly one cycle per accepted error word.
- R7: When the preset load is high, the accumulator becomes (preset - 4096) * 2^(11+shift), saturated to the 24-bit range. The code updates at the same edge and the strobe stays low. The load takes priority over a valid error word in the same cycle.
- R8: A change of the shift setting alone does not change the control code. The new shift takes effect at the next accepted error word.
- R9: In lock, alternating errors of +1 and -1 across a code boundary make the control code step between two adjacent values, and a zero error leaves the code unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Loop clock |
| rst | input | 1 | Synchronous active-high reset |
| chan_a | input | 18 | First corrected channel word, signed |
| chan_b | input | 18 | Second corrected channel word, signed |
| chan_vld | input | 1 | Both channel words valid this cycle |
| gain_shift | input | 3 | Right-shift amount applied after the accumulator |
| preset_ld | input | 1 | Load the accumulator from the preset code |
| preset_code | input | 13 | Offset-binary code to load |
| ctl_code | output | 13 | Offset-binary oscillator fine control code |
| ctl_upd | output | 1 | One-cycle pulse when ctl_code is updated from an error word |

## Verification
Some properties are checked by assertions on every cycle. The accumulator must not wrap when it moves in the direction of the error. Every accepted error word must produce a strobe one edge later. The code must stay put while neither a valid word nor a preset arrives.

Other behaviour can only be shown by the bench's scenarios against a reference model. These are the exact code values under different shifts, the saturation limits reached by long runs of full-scale error, the preset arithmetic and its priority over a valid word, the delayed effect of a shift change, and dithering around a code boundary.

// File: rtl/fll_loop_pkg.sv
package fll_loop_pkg;
  typedef enum logic [1:0] {
    OP_HOLD = 2'd0,
    OP_STEP = 2'd1,
    OP_LOAD = 2'd2
  } acc_op_e;
endpackage

// File: rtl/fll_err_sub.sv
module fll_err_sub #(
  parameter int CH_W = 18
) (
  input  logic signed [CH_W-1:0] a_i,
  input  logic signed [CH_W-1:0] b_i,
  output logic signed [CH_W:0]   err_o
);
  // full-precision difference, one guard bit
  always_comb begin
    err_o = {a_i[CH_W-1], a_i} - {b_i[CH_W-1], b_i};
  end
endmodule

// File: rtl/fll_acc_sat.sv
module fll_acc_sat
  import fll_loop_pkg::*;
#(
  parameter int ACC_W  = 24,
  parameter int CH_W   = 18,
  parameter int CODE_W = 13,
  parameter int SH_W   = 3
) (
  input  logic                   clk,
  input  logic                   rst,
  input  acc_op_e                op_i,
  input  logic signed [CH_W:0]   err_i,
  input  logic [CODE_W-1:0]      preset_i,
  input  logic [SH_W-1:0]        shift_i,
  output logic signed [ACC_W-1:0] acc_d_o
);
  localparam int FRAC  = ACC_W - CODE_W;
  localparam int WIDE  = ACC_W + (1 << SH_W) + 1;
  localparam int AMT_W = $clog2(FRAC + (1 << SH_W)) + 1;
  localparam logic signed [ACC_W-1:0] POS_LIM = {1'b0, {(ACC_W-1){1'b1}}};
  localparam logic signed [ACC_W-1:0] NEG_LIM = {1'b1, {(ACC_W-1){1'b0}}};

  logic signed [ACC_W-1:0] acc_q;
  logic signed [ACC_W:0]   sum;
  logic signed [ACC_W-1:0] step_val;
  logic signed [CODE_W-1:0] pre_s;
  logic signed [WIDE-1:0]  pre_wide;
  logic [AMT_W-1:0]        amt;
  logic [WIDE-ACC_W:0]     pre_top;
  logic signed [ACC_W-1:0] load_val;

  // step path: widened add, clamp on sign disagreement
  always_comb begin
    sum = {acc_q[ACC_W-1], acc_q} + {{(ACC_W-CH_W){err_i[CH_W]}}, err_i};
    if (sum[ACC_W] != sum[ACC_W-1]) begin
      step_val = sum[ACC_W] ? NEG_LIM : POS_LIM;
    end else begin
      step_val = sum[ACC_W-1:0];
    end
  end

  // preset path: offset code to signed, scaled by the current shift
  always_comb begin
    pre_s    = {~preset_i[CODE_W-1], preset_i[CODE_W-2:0]};
    amt      = AMT_W'(FRAC) + AMT_W'(shift_i);
    pre_wide = $signed({{(WIDE-CODE_W){pre_s[CODE_W-1]}}, pre_s}) <<< amt;
    pre_top  = pre_wide[WIDE-1:ACC_W-1];
    if ((&pre_top) || !(|pre_top)) begin
      load_val = pre_wide[ACC_W-1:0];
    end else begin
      load_val = pre_wide[WIDE-1] ? NEG_LIM : POS_LIM;
    end
  end

  always_comb begin
    unique case (op_i)
      OP_STEP: acc_d_o = step_val;
      OP_LOAD: acc_d_o = load_val;
      default: acc_d_o = acc_q;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) acc_q <= '0;
    else     acc_q <= acc_d_o;
  end

  // R4
  no_wrap_up_chk: assert property (@(posedge clk) disable iff (rst)
    (op_i == OP_STEP && !err_i[CH_W]) |=> ($signed(acc_q) >= $signed($past(acc_q))));

  // R4
  no_wrap_dn_chk: assert property (@(posedge clk) disable iff (rst)
    (op_i == OP_STEP && err_i[CH_W]) |=> ($signed(acc_q) <= $signed($past(acc_q))));

  // R3
  acc_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (op_i == OP_HOLD) |=> $stable(acc_q));
endmodule

// File: rtl/fll_code_map.sv
module fll_code_map #(
  parameter int CODE_W = 13,
  parameter int SH_W   = 3
) (
  input  logic [CODE_W-1:0] acc_hi_i,
  input  logic [SH_W-1:0]   shift_i,
  output logic [CODE_W-1:0] code_o
);
  logic signed [CODE_W-1:0] scaled;

  // floor(acc/2^FRAC) then floor(/2^shift) equals floor(acc/2^(FRAC+shift))
  always_comb begin
    scaled = $signed(acc_hi_i) >>> shift_i;
    code_o = {~scaled[CODE_W-1], scaled[CODE_W-2:0]};
  end
endmodule

// File: rtl/fll_err_integrator.sv
module fll_err_integrator
  import fll_loop_pkg::*;
#(
  parameter int CH_W   = 18,
  parameter int ACC_W  = 24,
  parameter int CODE_W = 13,
  parameter int SH_W   = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [CH_W-1:0]   chan_a,
  input  logic [CH_W-1:0]   chan_b,
  input  logic              chan_vld,
  input  logic [SH_W-1:0]   gain_shift,
  input  logic              preset_ld,
  input  logic [CODE_W-1:0] preset_code,
  output logic [CODE_W-1:0] ctl_code,
  output logic              ctl_upd
);
  localparam logic [CODE_W-1:0] MID = {1'b1, {(CODE_W-1){1'b0}}};

  logic signed [CH_W:0]    err;
  logic signed [ACC_W-1:0] acc_d;
  logic [CODE_W-1:0]       code_d;
  acc_op_e                 op;

  always_comb begin
    if (preset_ld)     op = OP_LOAD;
    else if (chan_vld) op = OP_STEP;
    else               op = OP_HOLD;
  end

  fll_err_sub #(.CH_W(CH_W)) u_sub (
    .a_i   ($signed(chan_a)),
    .b_i   ($signed(chan_b)),
    .err_o (err)
  );

  fll_acc_sat #(.ACC_W(ACC_W), .CH_W(CH_W), .CODE_W(CODE_W), .SH_W(SH_W)) u_acc (
    .clk      (clk),
    .rst      (rst),
    .op_i     (op),
    .err_i    (err),
    .preset_i (preset_code),
    .shift_i  (gain_shift),
    .acc_d_o  (acc_d)
  );

  fll_code_map #(.CODE_W(CODE_W), .SH_W(SH_W)) u_map (
    .acc_hi_i (acc_d[ACC_W-1 -: CODE_W]),
    .shift_i  (gain_shift),
    .code_o   (code_d)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl_code <= MID;
      ctl_upd  <= 1'b0;
    end else begin
      ctl_upd <= (op == OP_STEP);
      if (op != OP_HOLD) ctl_code <= code_d;
    end
  end

  // R6
  upd_follow_chk: assert property (@(posedge clk) disable iff (rst)
    (chan_vld && !preset_ld) |=> ctl_upd);

  // R7
  load_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    preset_ld |=> !ctl_upd);

  // R8
  code_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (!chan_vld && !preset_ld) |=> $stable(ctl_code));
endmodule

// File: tb/fll_err_integrator_test.sv
`timescale 1ns/1ps
module fll_err_integrator_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [17:0] chan_a = '0;
  logic [17:0] chan_b = '0;
  logic        chan_vld = 1'b0;
  logic [2:0]  gain_shift = '0;
  logic        preset_ld = 1'b0;
  logic [12:0] preset_code = '0;
  logic [12:0] ctl_code;
  logic        ctl_upd;

  int total = 0;
  int bad = 0;
  int cycles = 0;
  bit finished = 0;
  longint acc_m = 0;
  int exp_q[$];

  localparam longint POS = 64'sd8388607;
  localparam longint NEG = -64'sd8388608;

  always #2 clk = ~clk;

  fll_err_integrator uut (
    .clk(clk), .rst(rst), .chan_a(chan_a), .chan_b(chan_b), .chan_vld(chan_vld),
    .gain_shift(gain_shift), .preset_ld(preset_ld), .preset_code(preset_code),
    .ctl_code(ctl_code), .ctl_upd(ctl_upd)
  );

  function automatic longint clampv(longint v);
    if (v > POS) return POS;
    if (v < NEG) return NEG;
    return v;
  endfunction

  function automatic int code_of(longint acc, int sh);
    return int'((acc >>> (11 + sh)) + 4096);
  endfunction

  task automatic check(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // monitor: pops the scoreboard whenever the design signals an update
  always @(negedge clk) begin
    if (!rst && ctl_upd) begin
      if (exp_q.size() == 0) check("R6 unexpected strobe", 1, 0);
      else check("R5/R6 code", int'(ctl_code), exp_q.pop_front());
    end
  end

  task automatic step(int a, int b);
    @(negedge clk);
    chan_a = 18'(a);
    chan_b = 18'(b);
    chan_vld = 1'b1;
    acc_m = clampv(acc_m + longint'(a) - longint'(b));
    exp_q.push_back(code_of(acc_m, int'(gain_shift)));
    @(negedge clk);
    chan_vld = 1'b0;
  endtask

  task automatic load(int code, bit with_vld);
    @(negedge clk);
    preset_code = 13'(code);
    preset_ld = 1'b1;
    chan_vld = with_vld;
    chan_a = 18'(1000);
    chan_b = 18'(0);
    acc_m = clampv((longint'(code) - 4096) * (64'sd1 <<< (11 + int'(gain_shift))));
    @(negedge clk);
    preset_ld = 1'b0;
    chan_vld = 1'b0;
    check("R7 load strobe low", int'(ctl_upd), 0);
    check("R7 load code", int'(ctl_code), code_of(acc_m, int'(gain_shift)));
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000 && !finished) begin
        finished = 1;
        bad++;
        total++;
        $display("FAIL watchdog: actual=%0d expected=<100000", cycles);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check("R1 reset code", int'(ctl_code), 4096);
    check("R1 reset strobe", int'(ctl_upd), 0);

    // R2 R3 R5 signed differences at shift 0
    step(3000, 1000);
    step(-5000, 2000);
    step(-100000, 100000);
    step(131071, -131072);
    // R3 idle cycles keep the code
    repeat (4) @(negedge clk);
    check("R3 hold", int'(ctl_code), code_of(acc_m, 0));
    check("R6 strobe idle", int'(ctl_upd), 0);

    // R4 positive saturation
    for (int i = 0; i < 40; i++) step(131071, -131072);
    check("R4 pos limit", int'(ctl_code), 8191);
    // R4 negative saturation
    for (int i = 0; i < 80; i++) step(-131072, 131071);
    check("R4 neg limit", int'(ctl_code), 0);

    // R5 several shifts
    for (int s = 0; s < 8; s++) begin
      @(negedge clk);
      gain_shift = 3'(s);
      load(4096 + 100, 1'b0);
      step(70000, 3);
      step(-20000, 11);
    end

    // R7 preset saturation at large shift and priority over valid
    @(negedge clk);
    gain_shift = 3'd7;
    load(8000, 1'b0);
    load(100, 1'b1);
    gain_shift = 3'd0;
    load(5000, 1'b1);

    // R8 shift change alone keeps the code
    @(negedge clk);
    gain_shift = 3'd3;
    repeat (3) @(negedge clk);
    check("R8 shift alone", int'(ctl_code), code_of(acc_m, 0));
    step(0, 0);
    check("R8 new shift applied", int'(ctl_code), code_of(acc_m, 3));

    // R9 dither around a code boundary
    @(negedge clk);
    gain_shift = 3'd0;
    load(4096, 1'b0);
    step(2047, 0);
    for (int i = 0; i < 4; i++) begin
      step(1, 0);
      check("R9 dither high", int'(ctl_code), 4097);
      step(0, 1);
      check("R9 dither low", int'(ctl_code), 4096);
    end
    step(0, 0);
    check("R9 zero error", int'(ctl_code), 4096);

    // R1 reset mid-run
    step(50000, 0);
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    acc_m = 0;
    check("R1 reset code again", int'(ctl_code), 4096);
    step(4096, 0);
    check("R1 accumulator cleared", int'(ctl_code), 4098);

    repeat (2) @(negedge clk);
    check("R6 scoreboard drained", exp_q.size(), 0);
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule